// File: doc/BRIEF.md
# Command Mailbox Register Block

This block is the device-side window through which host software runs management commands, one at a time. The host reaches it over a plain 32-bit word bus. It holds five things: a 64-byte command area, a read-only 16-byte completion area, a shared data area for command parameters and results, a done flag and a doorbell. A separate read-only identity region tells software what it is talking to.

The host first clears done and fills in the command, plus any input parameters in the data area. It then writes the doorbell. The stored command is offered to an external executor on a valid/ready handshake. While it works, the executor may write results into the data area. It finishes with a single completion pulse. The block latches that completion and sets done, and the host then reads the status byte and any returned data.

Ringing the doorbell again replays the stored command without rewriting it. This is how software retries after a "try again" status. A doorbell that arrives while a command is still outstanding is dropped and recorded in a sticky overrun flag.

Top module: `cmd_mailbox`

## Requirements
- R1: Reset clears done, overrun and the busy state and drops cmd_valid. This holds even when a command is outstanding. The identity region reads the same before and after reset.
- R2: Writing the doorbell (byte 0x804) with bit 0 set while idle raises cmd_valid on the following cycle. cmd_payload bits 32k+31:32k carry command word k, which the host writes at byte 0x840+4k for k from 0 to 15. Bits 7:0 are the opcode byte. A doorbell write with bit 0 clear has no effect.
- R3: cmd_valid stays high with cmd_payload unchanged until a cycle with cmd_ready high. Host writes to the command area are ignored from launch until the completion.
- R4: A comp_valid pulse is taken only after the command has been accepted. Once taken, completion word k (bytes 0x880+4k, k from 0 to 3) reads comp_payload bits 32k+31:32k, and done (byte 0x800, bit 0) reads 1. The status byte is comp_payload bits 7:0. A comp_valid pulse while idle changes neither done nor the completion area.
- R5: Writing the done register with bit 0 clear clears done. Writing it with bit 0 set leaves done unchanged.
- R6: A doorbell with bit 0 set while a command is outstanding is ignored and sets the sticky overrun flag (byte 0x808, bit 0). Writing 1 to bit 0 of that register clears the flag. Writing 0 has no effect.
- R7: Ringing the doorbell again with no command-area writes presents the same 64-byte payload as the previous launch.
- R8: The identity region (bytes 0x000 to 0x7FF) is read-only and laid out by word:
  - word 0: the signature parameter.
  - word 1: bits 7:0 are the chip type and bits 15:8 the chip revision.
  - words 2 to 5: the firmware version string.
  - words 6 to 9: the serial number string.
  - In both strings, string word j equals parameter bits 32j+31:32j.
  - All other identity words read 0, and host writes do not change the region.
- R9: Data word i (byte 0xC00+4i, i below DATA_WORDS) can be read and written by the host. The executor can write it through ex_data_we while a command is outstanding. Executor writes while idle are ignored. ex_data_rdata shows the word at ex_data_addr. If both sides write the same word in one cycle, the executor's value is kept.
- R10: host_rdata presents the addressed word on the cycle after host_rd is sampled. The doorbell, data words at or above DATA_WORDS, and unmapped offsets read 0.
- R11: The status byte passes through unchanged for every defined code: 0 success, 1 bad version, 2 bad opcode, 3 I/O error, 4 busy, 5 try again, 6 invalid argument, 7 no space, 8 out of range, 9 bad address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 12 | Host byte address (word aligned) |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, one cycle after host_rd |
| cmd_valid | output | 1 | Command offered to executor |
| cmd_ready | input | 1 | Executor accepts the command |
| cmd_payload | output | 512 | The 64-byte command |
| comp_valid | input | 1 | Executor completion pulse |
| comp_payload | input | 128 | The 16-byte completion |
| ex_data_we | input | 1 | Executor data-area write enable |
| ex_data_addr | input | clog2(DATA_WORDS), at least 1 | Executor data-area word index |
| ex_data_wdata | input | 32 | Executor data-area write data |
| ex_data_rdata | output | 32 | Data-area word at ex_data_addr |

## Verification
The assertions watch the launch handshake on every cycle:
- cmd_valid only rises after an idle doorbell, and the payload holds steady while it is unacknowledged.
- done only rises on a completion taken after acceptance.
- overrun only rises on a doorbell that lands while a command is outstanding.
- Each release from reset leaves done, overrun and busy clear.

The byte-level register layout can only be shown by the bench's sweeps, because that needs stimulus and computed expected values:
- identity words and strings
- the command-word-to-payload mapping
- the data area
- passing through of each status code
- replay after a retry status
- ignored writes to locked or read-only areas

// File: rtl/mbx_pkg.sv
package mbx_pkg;
   localparam int HOST_AW    = 12;
   localparam int WORD_AW    = HOST_AW - 2;
   localparam int CMD_BYTES  = 64;
   localparam int COMP_BYTES = 16;
   localparam int CMD_WORDS  = CMD_BYTES / 4;
   localparam int COMP_WORDS = COMP_BYTES / 4;
   localparam int CMD_W      = CMD_BYTES * 8;
   localparam int COMP_W     = COMP_BYTES * 8;
   localparam int STR_BYTES  = 16;
   localparam int STR_W      = STR_BYTES * 8;
   localparam int DATA_MAX   = 256;

   // word indices (byte address / 4)
   localparam logic [WORD_AW-1:0] W_DONE  = 10'h200;
   localparam logic [WORD_AW-1:0] W_BELL  = 10'h201;
   localparam logic [WORD_AW-1:0] W_OVR   = 10'h202;
   localparam logic [WORD_AW-1:0] W_CMD0  = 10'h210;
   localparam logic [WORD_AW-1:0] W_COMP0 = 10'h220;
   localparam logic [WORD_AW-1:0] W_DATA0 = 10'h300;

   typedef enum logic [7:0] {
      ST_OK       = 8'd0,
      ST_BAD_VER  = 8'd1,
      ST_BAD_OP   = 8'd2,
      ST_IO       = 8'd3,
      ST_BUSY     = 8'd4,
      ST_AGAIN    = 8'd5,
      ST_INVAL    = 8'd6,
      ST_NOSPC    = 8'd7,
      ST_RANGE    = 8'd8,
      ST_BAD_ADDR = 8'd9
   } mbx_status_e;

   typedef enum logic [1:0] {
      S_IDLE  = 2'd0,
      S_OFFER = 2'd1,
      S_RUN   = 2'd2
   } mbx_state_e;
endpackage

// File: rtl/mbx_ident_rom.sv
module mbx_ident_rom
   import mbx_pkg::*;
#(
   parameter logic [31:0]    SIGNATURE = 32'h5A4D_4258,
   parameter logic [7:0]     CHIP_TYPE = 8'h21,
   parameter logic [7:0]     CHIP_REV  = 8'h03,
   parameter logic [STR_W-1:0] FW_VER  = '0,
   parameter logic [STR_W-1:0] SERIAL  = '0
) (
   input  logic [8:0]  widx,
   output logic [31:0] word
);
   localparam int SLOTS     = 16;
   localparam int STR_WORDS = STR_W / 32;
   localparam int FW_BASE   = 2;
   localparam int SN_BASE   = FW_BASE + STR_WORDS;

   if (SN_BASE + STR_WORDS > SLOTS) begin : g_bad_layout
      $error("identity layout does not fit in %0d slots", SLOTS);
   end

   logic [31:0] slot [SLOTS];

   for (genvar k = 0; k < SLOTS; k++) begin : g_slot
      if (k == 0) begin : g_sig
         assign slot[k] = SIGNATURE;
      end else if (k == 1) begin : g_chip
         assign slot[k] = {16'h0000, CHIP_REV, CHIP_TYPE};
      end else if (k >= FW_BASE && k < SN_BASE) begin : g_fw
         assign slot[k] = FW_VER[32*(k-FW_BASE) +: 32];
      end else if (k >= SN_BASE && k < SN_BASE + STR_WORDS) begin : g_sn
         assign slot[k] = SERIAL[32*(k-SN_BASE) +: 32];
      end else begin : g_zero
         assign slot[k] = 32'h0;
      end
   end

   assign word = (widx[8:4] == 5'd0) ? slot[widx[3:0]] : 32'h0;
endmodule

// File: rtl/mbx_data_ram.sv
module mbx_data_ram #(
   parameter int DEPTH = 64,
   parameter int AW    = 6
) (
   input  logic          clk,
   input  logic          host_we,
   input  logic [AW-1:0] host_idx,
   input  logic [31:0]   host_wdata,
   input  logic          ex_we,
   input  logic [AW-1:0] ex_idx,
   input  logic [31:0]   ex_wdata,
   output logic [31:0]   host_rdata,
   output logic [31:0]   ex_rdata
);
   if ((1 << AW) != DEPTH) begin : g_bad_aw
      $error("data area depth %0d must equal 2**%0d", DEPTH, AW);
   end

   logic [31:0] mem [DEPTH];

   // executor write placed last so it wins on a same-word collision
   always_ff @(posedge clk) begin
      if (host_we) mem[host_idx] <= host_wdata;
      if (ex_we)   mem[ex_idx]   <= ex_wdata;
   end

   assign host_rdata = mem[host_idx];
   assign ex_rdata   = mem[ex_idx];
endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
   import mbx_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic bell_hit,
   input  logic done_clr,
   input  logic ovr_clr,
   input  logic cmd_ready,
   input  logic comp_valid,
   output logic cmd_valid,
   output logic comp_take,
   output logic busy,
   output logic done,
   output logic ovr
);
   mbx_state_e state;

   assign cmd_valid = (state == S_OFFER);
   assign busy      = (state != S_IDLE);
   assign comp_take = (state == S_RUN) && comp_valid;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= S_IDLE;
         done  <= 1'b0;
         ovr   <= 1'b0;
      end else begin
         unique case (state)
            S_IDLE:  if (bell_hit)   state <= S_OFFER;
            S_OFFER: if (cmd_ready)  state <= S_RUN;
            S_RUN:   if (comp_valid) state <= S_IDLE;
            default:                 state <= S_IDLE;
         endcase

         if (comp_take)     done <= 1'b1;
         else if (done_clr) done <= 1'b0;

         if (bell_hit && state != S_IDLE) ovr <= 1'b1;
         else if (ovr_clr)                ovr <= 1'b0;
      end
   end
endmodule

// File: rtl/cmd_mailbox.sv
module cmd_mailbox
   import mbx_pkg::*;
#(
   parameter int               DATA_WORDS = 64,
   parameter logic [31:0]      SIGNATURE  = 32'h5A4D_4258,
   parameter logic [7:0]       CHIP_TYPE  = 8'h21,
   parameter logic [7:0]       CHIP_REV   = 8'h03,
   parameter logic [STR_W-1:0] FW_VER     = 128'h0000_0000_6232_2E31_2E34_2E30_2D72_6576,
   parameter logic [STR_W-1:0] SERIAL     = 128'h0000_0000_0000_3930_3837_3635_3433_3231,
   localparam int              DW_AW      = (DATA_WORDS > 1) ? $clog2(DATA_WORDS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic              host_rd,
   input  logic [11:0]       host_addr,
   input  logic [31:0]       host_wdata,
   output logic [31:0]       host_rdata,
   output logic              cmd_valid,
   input  logic              cmd_ready,
   output logic [511:0]      cmd_payload,
   input  logic              comp_valid,
   input  logic [127:0]      comp_payload,
   input  logic              ex_data_we,
   input  logic [DW_AW-1:0]  ex_data_addr,
   input  logic [31:0]       ex_data_wdata,
   output logic [31:0]       ex_data_rdata
);
   if (DATA_WORDS > DATA_MAX || (DATA_WORDS & (DATA_WORDS - 1)) != 0) begin : g_bad_depth
      $error("DATA_WORDS must be 0 or a power of two up to %0d", DATA_MAX);
   end
   if (CMD_W != 512 || COMP_W != 128) begin : g_bad_sizes
      $error("command/completion sizes do not match the port widths");
   end

   // ---------------- address decode ----------------
   logic [WORD_AW-1:0] widx;
   logic               addr_lo_unused;
   assign widx           = host_addr[HOST_AW-1:2];
   assign addr_lo_unused = ^host_addr[1:0];

   logic id_sel, done_sel, bell_sel, ovr_sel, cmd_sel, comp_sel, data_sel;
   assign id_sel   = ~widx[WORD_AW-1];
   assign done_sel = (widx == W_DONE);
   assign bell_sel = (widx == W_BELL);
   assign ovr_sel  = (widx == W_OVR);
   assign cmd_sel  = (widx[WORD_AW-1:4] == W_CMD0[WORD_AW-1:4]);
   assign comp_sel = (widx[WORD_AW-1:2] == W_COMP0[WORD_AW-1:2]);
   assign data_sel = (widx[WORD_AW-1:8] == W_DATA0[WORD_AW-1:8]) &&
                     (32'(widx[7:0]) < DATA_WORDS);

   logic bell_hit, done_clr, ovr_clr;
   assign bell_hit = host_wr & bell_sel & host_wdata[0];
   assign done_clr = host_wr & done_sel & ~host_wdata[0];
   assign ovr_clr  = host_wr & ovr_sel  &  host_wdata[0];

   // ---------------- launch / done control ----------------
   logic comp_take, busy_q, done_q, ovr_q;

   mbx_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .bell_hit   (bell_hit),
      .done_clr   (done_clr),
      .ovr_clr    (ovr_clr),
      .cmd_ready  (cmd_ready),
      .comp_valid (comp_valid),
      .cmd_valid  (cmd_valid),
      .comp_take  (comp_take),
      .busy       (busy_q),
      .done       (done_q),
      .ovr        (ovr_q)
   );

   // ---------------- command and completion areas ----------------
   logic [CMD_W-1:0]  cmd_q;
   logic [COMP_W-1:0] comp_q;
   logic [3:0]        cidx;
   assign cidx = widx[3:0];

   always_ff @(posedge clk) begin
      if (host_wr && cmd_sel && !busy_q) cmd_q[cidx*32 +: 32] <= host_wdata;
      if (comp_take)                     comp_q <= comp_payload;
   end

   assign cmd_payload = cmd_q;

   // ---------------- identity region ----------------
   logic [31:0] id_word;

   mbx_ident_rom #(
      .SIGNATURE (SIGNATURE),
      .CHIP_TYPE (CHIP_TYPE),
      .CHIP_REV  (CHIP_REV),
      .FW_VER    (FW_VER),
      .SERIAL    (SERIAL)
   ) u_ident (
      .widx (widx[8:0]),
      .word (id_word)
   );

   // ---------------- data area ----------------
   logic [31:0] data_rd;

   if (DATA_WORDS > 0) begin : g_data
      logic ex_we_g;
      assign ex_we_g = ex_data_we & busy_q;

      mbx_data_ram #(
         .DEPTH (DATA_WORDS),
         .AW    (DW_AW)
      ) u_ram (
         .clk        (clk),
         .host_we    (host_wr & data_sel),
         .host_idx   (widx[DW_AW-1:0]),
         .host_wdata (host_wdata),
         .ex_we      (ex_we_g),
         .ex_idx     (ex_data_addr),
         .ex_wdata   (ex_data_wdata),
         .host_rdata (data_rd),
         .ex_rdata   (ex_data_rdata)
      );
   end else begin : g_no_data
      logic ex_port_unused;
      assign ex_port_unused = ^{ex_data_we, ex_data_addr, ex_data_wdata};
      assign data_rd        = 32'h0;
      assign ex_data_rdata  = 32'h0;
   end

   // ---------------- host read path ----------------
   logic [31:0] rd_mux;

   always_comb begin
      rd_mux = 32'h0;
      if (id_sel)        rd_mux = id_word;
      else if (done_sel) rd_mux = {31'b0, done_q};
      else if (ovr_sel)  rd_mux = {31'b0, ovr_q};
      else if (cmd_sel)  rd_mux = cmd_q[cidx*32 +: 32];
      else if (comp_sel) rd_mux = comp_q[widx[1:0]*32 +: 32];
      else if (data_sel) rd_mux = data_rd;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       host_rdata <= 32'h0;
      else if (host_rd) host_rdata <= rd_mux;
   end
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker
   import mbx_pkg::*;
(
   input logic             clk,
   input logic             rst_n,
   input logic             cmd_valid,
   input logic             cmd_ready,
   input logic [CMD_W-1:0] cmd_payload,
   input logic             comp_valid,
   input logic             done_q,
   input logic             busy_q,
   input logic             ovr_q,
   input logic             bell_hit
);
   a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> (!done_q && !ovr_q && !busy_q && !cmd_valid))
      else $error("R1: state not cleared after reset");

   a_r2_launch_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cmd_valid) |-> $past(bell_hit && !busy_q))
      else $error("R2: cmd_valid rose without an idle doorbell");

   a_r3_offer_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_payload)))
      else $error("R3: offered command changed or dropped before ready");

   a_r4_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_q) |-> $past(comp_valid && busy_q && !cmd_valid))
      else $error("R4: done rose without an accepted completion");

   a_r6_overrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr_q) |-> $past(bell_hit && busy_q))
      else $error("R6: overrun rose without a busy doorbell");
endmodule

bind cmd_mailbox mbx_checker u_chk (.*);

// File: tb/cmd_mailbox_test.sv
`timescale 1ns/1ps
module cmd_mailbox_test;
   localparam int           DW       = 16;
   localparam int           AW       = 4;
   localparam logic [31:0]  SIG      = 32'hC0FF_EE42;
   localparam logic [7:0]   CTYPE    = 8'h5C;
   localparam logic [7:0]   CREV     = 8'hA1;
   localparam logic [127:0] FWV      = 128'h0011_2233_4455_6677_8899_AABB_CCDD_EEFF;
   localparam logic [127:0] SN       = 128'hF0E1_D2C3_B4A5_9687_7869_5A4B_3C2D_1E0F;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         host_wr = 1'b0, host_rd = 1'b0;
   logic [11:0]  host_addr = '0;
   logic [31:0]  host_wdata = '0;
   logic [31:0]  host_rdata;
   logic         cmd_valid, cmd_ready = 1'b0;
   logic [511:0] cmd_payload;
   logic         comp_valid = 1'b0;
   logic [127:0] comp_payload = '0;
   logic         ex_data_we = 1'b0;
   logic [AW-1:0] ex_data_addr = '0;
   logic [31:0]  ex_data_wdata = '0;
   logic [31:0]  ex_data_rdata;

   int vectors = 0;
   int miscompares = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   cmd_mailbox #(
      .DATA_WORDS (DW), .SIGNATURE (SIG), .CHIP_TYPE (CTYPE),
      .CHIP_REV (CREV), .FW_VER (FWV), .SERIAL (SN)
   ) uut (.*);

   // ---------- expected-value functions ----------
   function automatic logic [31:0] id_exp(input int k);
      if (k == 0) return SIG;
      if (k == 1) return {16'h0, CREV, CTYPE};
      if (k >= 2 && k < 6) return FWV[32*(k-2) +: 32];
      if (k >= 6 && k < 10) return SN[32*(k-6) +: 32];
      return 32'h0;
   endfunction

   function automatic logic [31:0] cpat(input int k);
      return {8'(8'h40 + k), 8'(k*3), 8'(k*5 + 1), (k == 0) ? 8'h2A : 8'(k)};
   endfunction

   function automatic logic [31:0] dpat(input int i);
      return 32'hA500_0000 ^ (32'(i) * 32'h0101_0101) ^ 32'(i << 20);
   endfunction

   function automatic logic [127:0] comp_pat(input int s);
      return {32'hDEC0_0000 + 32'(s), 32'h1234_0000 + 32'(s*7),
              32'h0BAD_0000 ^ 32'(s), {16'hC0DE, 8'(s*3), 8'(s)}};
   endfunction

   // ---------- check and bus tasks ----------
   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic host_write(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      host_wr = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic host_read(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      host_rd = 1'b1; host_addr = a;
      @(negedge clk);
      host_rd = 1'b0;
      d = host_rdata;
   endtask

   task automatic read_check(input string req, input string what,
                             input logic [11:0] a, input logic [31:0] exp);
      logic [31:0] d;
      host_read(a, d);
      check(req, what, d, exp);
   endtask

   // accept the offered command, then return one completion
   task automatic execute(input logic [127:0] cp);
      for (int i = 0; i < 50 && !cmd_valid; i++) @(negedge clk);
      check("R2", "cmd_valid before accept", {31'b0, cmd_valid}, 32'd1);
      cmd_ready = 1'b1;
      @(negedge clk);
      cmd_ready = 1'b0;
      check("R3", "cmd_valid after accept", {31'b0, cmd_valid}, 32'd0);
      comp_valid = 1'b1; comp_payload = cp;
      @(negedge clk);
      comp_valid = 1'b0;
   endtask

   initial begin
      #1_500_000;
      if (!finished) begin
         miscompares++;
         $display("FAIL watchdog: actual hung run, expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      check("R1", "cmd_valid after reset", {31'b0, cmd_valid}, 32'd0);
      read_check("R1", "done after reset", 12'h800, 32'd0);
      read_check("R1", "overrun after reset", 12'h808, 32'd0);

      // R8: identity sweep and write protection
      for (int k = 0; k < 16; k++) read_check("R8", $sformatf("ident word %0d", k), 12'(k*4), id_exp(k));
      read_check("R8", "ident top word", 12'h7FC, 32'h0);
      host_write(12'h000, 32'h1111_2222);
      host_write(12'h008, 32'h3333_4444);
      read_check("R8", "signature after write", 12'h000, SIG);
      read_check("R8", "fw word after write", 12'h008, id_exp(2));

      // R9 / R10: data area sweep, out-of-range and doorbell reads
      for (int i = 0; i < DW; i++) host_write(12'(12'hC00 + i*4), dpat(i));
      for (int i = 0; i < DW; i++) read_check("R9", $sformatf("data word %0d", i), 12'(12'hC00 + i*4), dpat(i));
      read_check("R10", "data beyond depth", 12'(12'hC00 + DW*4), 32'h0);
      read_check("R10", "doorbell read", 12'h804, 32'h0);
      read_check("R10", "unmapped read", 12'h8F0, 32'h0);

      // R2: command fill, dead doorbell, live doorbell
      for (int k = 0; k < 16; k++) host_write(12'(12'h840 + k*4), cpat(k));
      for (int k = 0; k < 16; k++) read_check("R2", $sformatf("cmd readback %0d", k), 12'(12'h840 + k*4), cpat(k));
      host_write(12'h804, 32'h0000_0002);
      @(negedge clk);
      check("R2", "bit0 clear doorbell", {31'b0, cmd_valid}, 32'd0);
      host_write(12'h804, 32'h1);
      check("R2", "cmd_valid after ring", {31'b0, cmd_valid}, 32'd1);
      for (int k = 0; k < 16; k++) check("R2", $sformatf("payload word %0d", k), cmd_payload[32*k +: 32], cpat(k));
      check("R2", "opcode byte", {24'b0, cmd_payload[7:0]}, 32'h2A);

      // R3: held offer, locked command area; R6: overrun
      repeat (3) @(negedge clk);
      check("R3", "cmd_valid held", {31'b0, cmd_valid}, 32'd1);
      host_write(12'h840, 32'hFFFF_FFFF);
      read_check("R3", "locked cmd word", 12'h840, cpat(0));
      check("R3", "payload stable", cmd_payload[31:0], cpat(0));
      host_write(12'h804, 32'h1);
      read_check("R6", "overrun set", 12'h808, 32'd1);
      check("R6", "busy ring ignored", {31'b0, cmd_valid}, 32'd1);

      // accept, executor data traffic, completion
      cmd_ready = 1'b1;
      @(negedge clk);
      cmd_ready = 1'b0;
      check("R3", "cmd_valid dropped", {31'b0, cmd_valid}, 32'd0);
      ex_data_addr = 4'd5;
      #1 check("R9", "ex_data_rdata", ex_data_rdata, dpat(5));
      ex_data_we = 1'b1; ex_data_addr = 4'd3; ex_data_wdata = 32'h7E57_0003;
      @(negedge clk);
      ex_data_we = 1'b0;
      // same-word collision: executor wins
      host_wr = 1'b1; host_addr = 12'hC1C; host_wdata = 32'h0000_0707;
      ex_data_we = 1'b1; ex_data_addr = 4'd7; ex_data_wdata = 32'hE000_0007;
      @(negedge clk);
      host_wr = 1'b0; ex_data_we = 1'b0;
      read_check("R9", "executor write", 12'hC0C, 32'h7E57_0003);
      read_check("R9", "collision winner", 12'hC1C, 32'hE000_0007);
      read_check("R4", "done before completion", 12'h800, 32'd0);
      comp_valid = 1'b1; comp_payload = comp_pat(0);
      @(negedge clk);
      comp_valid = 1'b0;
      read_check("R4", "done after completion", 12'h800, 32'd1);
      for (int k = 0; k < 4; k++) read_check("R4", $sformatf("comp word %0d", k), 12'(12'h880 + k*4), comp_pat(0)[32*k +: 32]);

      // R11 / R7 / R5: status sweep with replay
      for (int s = 0; s < 10; s++) begin
         host_write(12'h800, 32'h0);
         read_check("R5", "done cleared", 12'h800, 32'd0);
         host_write(12'h804, 32'h1);
         if (s == 5 || s == 9)
            for (int k = 0; k < 16; k++) check("R7", $sformatf("replay word %0d", k), cmd_payload[32*k +: 32], cpat(k));
         execute(comp_pat(s));
         read_check("R11", $sformatf("done for status %0d", s), 12'h800, 32'd1);
         host_read(12'h880, d);
         check("R11", "status byte", {24'b0, d[7:0]}, 32'(s));
         read_check("R11", "comp word 3", 12'h88C, comp_pat(s)[127:96]);
      end

      // R5: bit0 set does not clear
      host_write(12'h800, 32'h1);
      read_check("R5", "done kept on write 1", 12'h800, 32'd1);

      // R6: clear semantics
      host_write(12'h808, 32'h0);
      read_check("R6", "overrun kept on write 0", 12'h808, 32'd1);
      host_write(12'h808, 32'h1);
      read_check("R6", "overrun cleared", 12'h808, 32'd0);

      // R4: completion while idle ignored
      host_write(12'h800, 32'h0);
      comp_valid = 1'b1; comp_payload = {96'h0, 32'h0000_0077};
      @(negedge clk);
      comp_valid = 1'b0;
      read_check("R4", "idle comp done", 12'h800, 32'd0);
      read_check("R4", "idle comp word 0", 12'h880, comp_pat(9)[31:0]);

      // R9: executor write while idle ignored
      ex_data_we = 1'b1; ex_data_addr = 4'd2; ex_data_wdata = 32'hBAD0_BAD0;
      @(negedge clk);
      ex_data_we = 1'b0;
      read_check("R9", "idle executor write", 12'hC08, dpat(2));

      // R1: reset with a command outstanding
      host_write(12'h804, 32'h1);
      host_write(12'h804, 32'h1);
      check("R1", "offer before reset", {31'b0, cmd_valid}, 32'd1);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      check("R1", "cmd_valid after mid reset", {31'b0, cmd_valid}, 32'd0);
      read_check("R1", "overrun after mid reset", 12'h808, 32'd0);
      read_check("R1", "done after mid reset", 12'h800, 32'd0);
      read_check("R1", "identity after reset", 12'h004, id_exp(1));

      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule